// File: doc/BRIEF.md
# Per-Line Level Serializer with Peak Flag

This block turns one analog level per scan line into a short serial word. Each horizontal sync pulse starts a six-step successive-approximation search. The block drives a trial code to an external DAC. It reads back one comparator bit that says whether the held line level is at or above that trial. The search keeps or drops one bit per clock, starting with the most significant bit.

When the search ends, the code is inverted so that a bright line reads low and a dark line reads high. It is then shifted out as a 7-bit frame: six code bits, most significant first, and then one flag bit. The flag bit shows whether the luminance peak detector fired during the line. The frame for a line leaves the block during the following line period. A one-cycle strobe marks the end of each frame.

Top module: `line_level_serializer`

## Requirements
- R1: While reset is asserted and after its release, with no sync pulse yet, `dac_code` is 0 and `ser_data`, `ser_valid` and `frame_done` are all low.
- R2: In the cycle after `hsync` is sampled high, `dac_code` is 0x20. This is the most significant trial bit alone.
- R3: Over the six cycles after `hsync`, `dac_code` shows the trials for bits 5 down to 0, one bit per cycle. Each trial is the bits kept so far plus the bit under test. A bit is kept when `cmp_hi` is high in the cycle its trial is shown.
- R4: The transmitted code is the bitwise inverse of the search result. A level at or above every trial (fully white) sends 0x00. A level below every trial (fully black) sends 0x3F.
- R5: `ser_valid` is high for exactly 7 consecutive cycles, starting in the cycle after the sixth trial. `ser_data` carries code bit 5 first, then bits 4 to 0, and then the peak flag.
- R6: The peak flag is 1 when `peak_in` was high in any cycle from the previous `hsync`, excluded, up to and including the `hsync` cycle that starts the conversion. Otherwise it is 0. The collected state clears at each `hsync`.
- R7: `frame_done` is high for exactly one cycle, in the cycle right after the last frame bit. It is low at all other times.
- R8: An `hsync` that arrives during a search or a frame drops that work and starts a new search at once. No part of the dropped frame is sent later, and no `frame_done` follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| hsync | input | 1 | One-cycle line sync pulse; starts a conversion |
| cmp_hi | input | 1 | Comparator: held level is at or above `dac_code` |
| peak_in | input | 1 | Luminance peak detector output |
| dac_code | output | 6 | Trial code to the external DAC; 0 when idle |
| ser_data | output | 1 | Serial frame data |
| ser_valid | output | 1 | High while a frame bit is on `ser_data` |
| frame_done | output | 1 | One-cycle strobe after the last frame bit |

## Verification
Several rules are checked on every cycle by the assertions:
- each accepted trial is followed by a larger trial, and each rejected trial by a smaller one;
- a sync pulse always yields the MSB-only trial next;
- the valid window does not break before its last bit;
- the done strobe lasts one cycle and follows a valid cycle;
- a peak seen in the sync cycle reaches the flag.

Only the bench scenarios can show the following: the exact code values across many levels; the inverted mapping at the white and black extremes; the bit order and timing of each frame against a scoreboard; the one-line peak window; and that an interrupted frame never shows up later.

// File: rtl/lls_pkg.sv
package lls_pkg;
  typedef enum logic {
    SAR_IDLE = 1'b0,
    SAR_RUN  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/peak_latch.sv
module peak_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic pk_i,
  output logic flag_o
);
  logic sticky_q, sticky_d;
  logic flag_q, flag_d;

  always_comb begin
    sticky_d = sticky_q | pk_i;
    flag_d   = flag_q;
    if (clr_i) begin
      sticky_d = 1'b0;
      flag_d   = sticky_q | pk_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      flag_q   <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R6
  peak_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && pk_i) |=> flag_o);
  // R6
  no_peak_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !pk_i && !sticky_q) |=> !flag_o);
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_o,
  output logic              last_o,
  output logic [CODE_W-1:0] code_o
);
  import lls_pkg::*;

  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(CODE_W - 1);
  localparam logic [CODE_W-1:0] ONE = {{(CODE_W-1){1'b0}}, 1'b1};

  sar_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CODE_W-1:0] res_q, res_d;
  logic [CODE_W-1:0] bit_mask;
  logic              running;

  assign running  = (st_q == SAR_RUN);
  assign bit_mask = ONE << idx_q;
  assign trial_o  = running ? (res_q | bit_mask) : '0;
  assign last_o   = running && (idx_q == '0) && !start_i;
  assign code_o   = cmp_i ? (res_q | bit_mask) : res_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    res_d = res_q;
    if (start_i) begin
      st_d  = SAR_RUN;
      idx_d = TOP_IDX;
      res_d = '0;
    end else if (running) begin
      res_d = code_o;
      if (idx_q == '0) begin
        st_d = SAR_IDLE;
      end else begin
        idx_d = idx_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SAR_IDLE;
      idx_q <= '0;
      res_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      res_q <= res_d;
    end
  end

  // R2
  first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (trial_o == (ONE << (CODE_W - 1))));
  // R3
  keep_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start_i && idx_q != '0 && cmp_i) |=> (trial_o > $past(trial_o)));
  // R3
  drop_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start_i && idx_q != '0 && !cmp_i) |=> (trial_o < $past(trial_o)));
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              peak_i,
  output logic              ser_o,
  output logic              valid_o,
  output logic              done_o
);
  localparam int FRAME_W = CODE_W + 1;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;
  logic               done_q, done_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    done_d = 1'b0;
    if (abort_i) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (load_i) begin
      sh_d  = {~code_i, peak_i};
      cnt_d = '0;
      act_d = 1'b1;
    end else if (act_q) begin
      sh_d = {sh_q[FRAME_W-2:0], 1'b0};
      if (cnt_q == LAST_CNT) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      done_q <= done_d;
    end
  end

  assign ser_o   = act_q & sh_q[FRAME_W-1];
  assign valid_o = act_q;
  assign done_o  = done_q;

  // R5
  window_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !abort_i && cnt_q != LAST_CNT) |=> valid_o);
  // R7
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!valid_o && $past(valid_o)));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/line_level_serializer.sv
module line_level_serializer #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              cmp_hi,
  input  logic              peak_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              ser_data,
  output logic              ser_valid,
  output logic              frame_done
);
  logic              sar_last;
  logic [CODE_W-1:0] sar_code;
  logic              line_peak;

  peak_latch u_peak (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (hsync),
    .pk_i   (peak_in),
    .flag_o (line_peak)
  );

  sar_core #(.CODE_W(CODE_W)) u_sar (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (hsync),
    .cmp_i   (cmp_hi),
    .trial_o (dac_code),
    .last_o  (sar_last),
    .code_o  (sar_code)
  );

  frame_shifter #(.CODE_W(CODE_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (hsync),
    .load_i  (sar_last),
    .code_i  (sar_code),
    .peak_i  (line_peak),
    .ser_o   (ser_data),
    .valid_o (ser_valid),
    .done_o  (frame_done)
  );

  // R8
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (!ser_valid && !frame_done));
endmodule

// File: tb/line_level_serializer_tb_top.sv
module line_level_serializer_tb_top;
  logic       clk;
  logic       rst_n;
  logic       hsync;
  logic       peak_in;
  logic [5:0] dac_code;
  logic       ser_data;
  logic       ser_valid;
  logic       frame_done;
  logic [5:0] level;
  logic       cmp_hi;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [6:0] exp_q[$];
  bit         finished = 0;

  assign cmp_hi = (level >= dac_code);

  line_level_serializer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsync      (hsync),
    .cmp_hi     (cmp_hi),
    .peak_in    (peak_in),
    .dac_code   (dac_code),
    .ser_data   (ser_data),
    .ser_valid  (ser_valid),
    .frame_done (frame_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Driver: start a line; pk_at_sync raises peak_in together with hsync.
  // With check_trials set, the R3 trial sequence is checked and the frame
  // is pushed to the scoreboard.
  task automatic run_line(input logic [5:0] lvl, input logic pk_at_sync,
                          input bit check_trials, input logic exp_peak);
    logic [5:0] res;
    logic [5:0] tr;
    level = lvl;
    @(negedge clk);
    hsync = 1'b1;
    peak_in = pk_at_sync;
    @(negedge clk);
    hsync = 1'b0;
    peak_in = 1'b0;
    if (check_trials) begin
      exp_q.push_back({~lvl, exp_peak});
      check("R2 first trial", 32'(dac_code), 32'h20);
      res = 6'd0;
      for (int b = 5; b >= 0; b--) begin
        tr = res | (6'd1 << b);
        check("R3 trial", 32'(dac_code), 32'(tr));
        if (lvl >= tr) res = tr;
        if (b > 0) @(negedge clk);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Monitor: collect frame bits, compare with the scoreboard, check the strobe
  initial begin
    logic [6:0] got;
    int nb;
    bit want_done;
    nb = 0;
    want_done = 0;
    got = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        nb = 0;
        want_done = 0;
      end else begin
        if (want_done) begin
          check("R7 done strobe", 32'(frame_done), 32'h1);
          want_done = 0;
        end else if (frame_done) begin
          check("R7 stray done", 32'(frame_done), 32'h0);
        end
        if (ser_valid) begin
          got = {got[5:0], ser_data};
          nb++;
          if (nb == 7) begin
            if (exp_q.size() == 0) begin
              check("R8 unexpected frame", 32'(got), 32'h80);
            end else begin
              logic [6:0] e;
              e = exp_q.pop_front();
              check("R4 R5 R6 frame", 32'(got), 32'(e));
            end
            nb = 0;
            want_done = 1;
          end
        end else begin
          nb = 0;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    hsync = 1'b0;
    peak_in = 1'b0;
    level = 6'd0;
    idle(3);
    // R1 reset state
    check("R1 dac_code", 32'(dac_code), 32'h0);
    check("R1 ser_valid", 32'(ser_valid), 32'h0);
    check("R1 ser_data", 32'(ser_data), 32'h0);
    check("R1 frame_done", 32'(frame_done), 32'h0);
    rst_n = 1'b1;
    idle(3);
    check("R1 idle after release", 32'({dac_code, ser_valid, frame_done}), 32'h0);

    // R4 white and black extremes, peak seen during the line before
    peak_in = 1'b1;
    @(negedge clk);
    peak_in = 1'b0;
    run_line(6'h3F, 1'b0, 1, 1'b1);
    idle(10);
    run_line(6'h00, 1'b0, 1, 1'b0);  // R6 flag cleared by previous sync
    idle(10);
    // R6 peak in the sync cycle itself counts
    run_line(6'h15, 1'b1, 1, 1'b1);
    idle(10);
    for (int k = 0; k < 10; k++) begin
      logic [5:0] l;
      l = 6'((k * 23 + 7) % 64);
      run_line(l, k[0], 1, k[0]);
      idle(10);
    end
    // R8 sync in the middle of a search
    run_line(6'h2A, 1'b0, 0, 1'b0);
    idle(2);
    run_line(6'h11, 1'b0, 1, 1'b0);
    idle(10);
    // R8 sync in the middle of a frame
    run_line(6'h33, 1'b1, 0, 1'b0);
    idle(9);
    check("R8 frame running", 32'(ser_valid), 32'h1);
    run_line(6'h0C, 1'b0, 1, 1'b0);
    idle(12);
    check("R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
    finish_run();
  end
endmodule